// File: doc/BRIEF.md
# Serial Register Read Responder

This block is the target end of a two-wire, host-clocked serial link. The host toggles a serial clock and sends a header byte on a shared bidirectional data line. The header's leading bit gives the direction, and the seven bits after it give a register address. The block runs on its own fast system clock. It oversamples both link wires through synchronizer chains and finds the serial clock edges in the system-clock domain.

On a read header, the block looks up the addressed byte in its internal register file. It then takes the data line and shifts that byte out, most significant bit first, changing the line only on falling serial clock edges. It keeps the last bit on the line until the next falling edge and only then lets go. On a write header, it collects the following byte into the addressed register and leaves the line alone. A separate local write port lets a test environment preload the register file.

Top module: `sreg_read_target`

## Requirements
- R1: After reset the target does not drive the data line (`sdio_oe` = 0) and waits for the first bit of a new header.
- R2: Link bits are sampled on rising serial clock edges. Rise 1 carries the direction bit (0 = read, 1 = write). Rises 2 to 8 carry the register address, most significant bit first.
- R3: On a read, the addressed byte appears on `sdio_out` most significant bit first. The host samples it on rises 9 to 16, and the output bit only changes after a falling edge.
- R4: The target never drives during the header. It takes the line at the first falling edge after rise 8, so `sdio_oe` is high on rises 9 to 16 of a read.
- R5: After rise 16 of a read, the last data bit (bit 0) stays driven until the next falling edge. After that edge the line is released.
- R6: On a write, rises 9 to 16 carry a data byte, most significant bit first, which is stored into the addressed register. `sdio_oe` stays low for the whole transaction.
- R7: After 16 rising edges the target returns to the header phase, so transactions can follow back to back without any idle marker.
- R8: A local write (`lw_en` high for one system clock) stores `lw_data` at `lw_addr`, and later serial reads return it. A local write takes priority over a serial write to the same cycle.
- R9: Whenever `sdio_oe` is low, `sdio_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_in | input | 1 | Serial clock from the host, idles high |
| sdio_in | input | 1 | Data line as seen at the target pin |
| sdio_out | output | 1 | Value the target drives onto the data line |
| sdio_oe | output | 1 | High while the target owns the data line |
| lw_en | input | 1 | Local write strobe |
| lw_addr | input | 7 | Local write register address |
| lw_data | input | 8 | Local write data byte |

## Verification
The bench builds the block with its default parameters: a 7-bit address, an 8-bit data byte and two synchronizer stages. This makes the full 128-entry register file reachable, including both end addresses 0 and 127, and gives a fixed count of 16 rising edges per transaction. The bench holds each serial clock level for six system clocks. That is longer than the two-stage synchronizer plus edge detector, so every drive change and release is visible before the next host sample.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Serial clock edge strobes and the resampled data bit, in system-clock domain.
  typedef struct packed {
    logic rise;
    logic fall;
    logic dat;
  } line_evt_t;

endpackage

// File: rtl/sreg_line_sync.sv
module sreg_line_sync
  import sreg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_in,
  input  logic      sdio_in,
  output line_evt_t evt
);

  logic [STAGES-1:0] sclk_pipe_q, sclk_pipe_d;
  logic [STAGES-1:0] sdio_pipe_q, sdio_pipe_d;
  logic              sclk_last_q, sclk_last_d;

  // Next-state: shift each pin through its own chain.
  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        sclk_pipe_d = sclk_in;
        sdio_pipe_d = sdio_in;
      end
    end else begin : g_many
      always_comb begin
        sclk_pipe_d = {sclk_pipe_q[STAGES-2:0], sclk_in};
        sdio_pipe_d = {sdio_pipe_q[STAGES-2:0], sdio_in};
      end
    end
  endgenerate

  assign sclk_last_d = sclk_pipe_q[STAGES-1];

  // Serial clock idles high, so reset to 1 to avoid a fake edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe_q <= '1;
      sdio_pipe_q <= '0;
      sclk_last_q <= 1'b1;
    end else begin
      sclk_pipe_q <= sclk_pipe_d;
      sdio_pipe_q <= sdio_pipe_d;
      sclk_last_q <= sclk_last_d;
    end
  end

  always_comb begin
    evt.rise = sclk_pipe_q[STAGES-1] & ~sclk_last_q;
    evt.fall = ~sclk_pipe_q[STAGES-1] & sclk_last_q;
    evt.dat  = sdio_pipe_q[STAGES-1];
  end

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              lw_en,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [DATA_W-1:0] lw_data,
  input  logic              sw_en,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Storage array: no reset, contents are defined by writes only.
  always_ff @(posedge clk) begin
    if (lw_en) begin
      mem_q[lw_addr] <= lw_data;
    end else if (sw_en) begin
      mem_q[sw_addr] <= sw_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sreg_link_ctrl.sv
module sreg_link_ctrl
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  line_evt_t                             evt,
  input  logic [DATA_W-1:0]                     rd_data,
  output logic [ADDR_W-1:0]                     reg_addr,
  output logic                                  sw_en,
  output logic [DATA_W-1:0]                     sw_data,
  output logic                                  sdio_out,
  output logic                                  sdio_oe,
  output logic [$clog2(1+ADDR_W+DATA_W)-1:0]    bit_cnt,
  output logic                                  is_write
);

  localparam int TOTAL = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wsh_q, wsh_d;
  logic [DATA_W-1:0] osh_q, osh_d;
  logic              oe_q, oe_d;

  // Next-state logic.
  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    addr_d  = addr_q;
    wsh_d   = wsh_q;
    osh_d   = osh_q;
    oe_d    = oe_q;
    sw_en   = 1'b0;
    sw_data = {wsh_q[DATA_W-2:0], evt.dat};

    if (evt.rise) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0) begin
        dir_d = evt.dat;
      end else if (cnt_q < CNT_HDR) begin
        addr_d = {addr_q[ADDR_W-2:0], evt.dat};
      end else begin
        wsh_d = {wsh_q[DATA_W-2:0], evt.dat};
        if (cnt_q == CNT_LAST && dir_q) begin
          sw_en = 1'b1;
        end
      end
    end

    if (evt.fall) begin
      if (cnt_q == CNT_HDR && !dir_q) begin
        osh_d = rd_data;
        oe_d  = 1'b1;
      end else if (oe_q && cnt_q > CNT_HDR) begin
        osh_d = {osh_q[DATA_W-2:0], 1'b0};
      end else if (oe_q && cnt_q == '0) begin
        oe_d = 1'b0;
      end
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      wsh_q  <= '0;
      osh_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      addr_q <= addr_d;
      wsh_q  <= wsh_d;
      osh_q  <= osh_d;
      oe_q   <= oe_d;
    end
  end

  assign reg_addr = addr_q;
  assign sdio_oe  = oe_q;
  assign sdio_out = oe_q & osh_q[DATA_W-1];
  assign bit_cnt  = cnt_q;
  assign is_write = dir_q;

endmodule

// File: rtl/sreg_read_target.sv
module sreg_read_target
  import sreg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  input  logic              lw_en,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [DATA_W-1:0] lw_data
);

  localparam int CNT_W = $clog2(1 + ADDR_W + DATA_W);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  line_evt_t         evt;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] rd_data;
  logic              sw_en;
  logic [DATA_W-1:0] sw_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              is_write;
  logic              sclk_rise;
  logic              sclk_fall;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  sreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk_in (sclk_in),
    .sdio_in (sdio_in),
    .evt     (evt)
  );

  assign sclk_rise = evt.rise;
  assign sclk_fall = evt.fall;

  sreg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .lw_en   (lw_en),
    .lw_addr (lw_addr),
    .lw_data (lw_data),
    .sw_en   (sw_en),
    .sw_addr (reg_addr),
    .sw_data (sw_data),
    .rd_addr (reg_addr),
    .rd_data (rd_data)
  );

  sreg_link_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .sw_en    (sw_en),
    .sw_data  (sw_data),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .bit_cnt  (bit_cnt),
    .is_write (is_write)
  );

endmodule

// File: rtl/sreg_read_target_chk.sv
module sreg_read_target_chk #(
  parameter int CNT_W = 4,
  parameter int HDR   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             is_write,
  input logic             sdio_oe,
  input logic             sdio_out
);

  // R4: drive starts only once the full header has been counted.
  p_drive_after_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (bit_cnt == CNT_W'(HDR) && $past(sclk_fall)));

  // R6: a write transaction never takes the line.
  p_write_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && bit_cnt != '0) |-> !sdio_oe);

  // R5: release happens only in response to a falling edge.
  p_release_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> $past(sclk_fall));

  // R3: while driving, the output bit moves only after a falling edge.
  p_bit_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$past(sclk_fall)) |-> $stable(sdio_out));

  // R7: the bit counter advances only on rising edges.
  p_count_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sclk_rise) |-> $stable(bit_cnt));

endmodule

bind sreg_read_target sreg_read_target_chk #(
  .CNT_W (CNT_W),
  .HDR   (1 + ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .bit_cnt   (bit_cnt),
  .is_write  (is_write),
  .sdio_oe   (sdio_oe),
  .sdio_out  (sdio_out)
);

// File: tb/sreg_read_target_tb.sv
module sreg_read_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int GAP        = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk_in;
  logic       sdio_in;
  logic       sdio_out;
  logic       sdio_oe;
  logic       lw_en;
  logic [6:0] lw_addr;
  logic [7:0] lw_data;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] model [128];
  logic [7:0] exp_q [$];
  bit         mon_en = 1'b0;
  int         mcnt = 0;
  logic       mdir = 1'b0;
  logic [7:0] macc = '0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_read_target dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .sdio_in  (sdio_in),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .lw_en    (lw_en),
    .lw_addr  (lw_addr),
    .lw_data  (lw_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: observes every host sampling edge and scores read data.
  always @(posedge sclk_in) begin
    if (mon_en) begin
      if (mcnt == 0) mdir = sdio_in;
      if (mcnt < 8) begin
        chk(!sdio_oe, "R4 no drive in header", int'(sdio_oe), 0);
      end else if (mdir) begin
        chk(!sdio_oe, "R6 write silent", int'(sdio_oe), 0);
      end else begin
        chk(sdio_oe, "R4 driving data phase", int'(sdio_oe), 1);
        macc = {macc[6:0], sdio_out};
        if (mcnt == 15) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected read", int'(macc), 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(macc == e, "R3 R2 read data", int'(macc), int'(e));
          end
        end
      end
      mcnt = (mcnt == 15) ? 0 : mcnt + 1;
    end
  end

  task automatic local_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    lw_en = 1'b1; lw_addr = a; lw_data = d;
    @(negedge clk);
    lw_en = 1'b0;
    model[a] = d;
  endtask

  task automatic xfer(input bit dir, input logic [6:0] a, input logic [7:0] wd);
    logic [15:0] frame;
    logic [7:0]  rv;
    frame = {dir, a, wd};
    rv = model[a];
    if (!dir) exp_q.push_back(rv);
    else      model[a] = wd;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      sdio_in = (dir || i < 8) ? frame[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i == 0) chk(!sdio_oe, "R5 released after trailing fall", int'(sdio_oe), 0);
      if (i == 8 && !dir) chk(sdio_oe && sdio_out == rv[7], "R4 R3 first bit", int'({sdio_oe, sdio_out}), int'({1'b1, rv[7]}));
      sclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == 7) repeat (GAP) @(negedge clk);
    end
    repeat (HALF) @(negedge clk);
    if (!dir) chk(sdio_oe && sdio_out == rv[0], "R5 last bit held", int'({sdio_oe, sdio_out}), int'({1'b1, rv[0]}));
    else      chk(!sdio_oe, "R6 no drive after write", int'(sdio_oe), 0);
  endtask

  initial begin
    rst_n = 1'b0; sclk_in = 1'b1; sdio_in = 1'b0;
    lw_en = 1'b0; lw_addr = '0; lw_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdio_oe && !sdio_out, "R1 R9 reset idle", int'({sdio_oe, sdio_out}), 0);
    mon_en = 1'b1;

    // R8: preload every register through the local port.
    for (int i = 0; i < 128; i++) local_wr(7'(i), 8'((i * 37 + 5) ^ 8'h5A));

    // R2 R3 R7: back-to-back reads over distinct address patterns.
    xfer(1'b0, 7'h00, 8'h00);
    xfer(1'b0, 7'h7F, 8'h00);
    xfer(1'b0, 7'h55, 8'h00);
    xfer(1'b0, 7'h2A, 8'h00);
    xfer(1'b0, 7'h01, 8'h00);
    xfer(1'b0, 7'h40, 8'h00);
    for (int i = 0; i < 6; i++) xfer(1'b0, 7'((i * 29 + 3) % 128), 8'h00);

    // R6: serial writes, then read back.
    xfer(1'b1, 7'h10, 8'hA5);
    xfer(1'b0, 7'h10, 8'h00);
    xfer(1'b1, 7'h7F, 8'h00);
    xfer(1'b1, 7'h00, 8'hFF);
    xfer(1'b0, 7'h7F, 8'h00);
    xfer(1'b0, 7'h00, 8'h00);

    // R8: local write overrides earlier serial write.
    local_wr(7'h10, 8'h3C);
    xfer(1'b0, 7'h10, 8'h00);

    // R5 R9: trailing falling edge releases the line.
    @(negedge clk);
    sclk_in = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(!sdio_oe && !sdio_out, "R5 R9 final release", int'({sdio_oe, sdio_out}), 0);
    chk(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule